// File: doc/BRIEF.md
# Interrupt Priority Resolver for One Target

This block serves a single interrupt target. Each cycle it looks at a vector of pending flags, one flag per source, and at this target's enable mask. It also takes a priority value for every source and the target's threshold. From the sources that are both pending and enabled, it picks the one with the largest priority. When several sources share that priority, the one with the smallest ID wins. The block outputs the winner's ID. It raises a request line only when the winner's priority is strictly greater than the threshold.

A source's ID is its bit position in the pending vector. Bit 0 is reserved to mean "no interrupt", and the block never selects it. The threshold gates only the request line. The reported ID is therefore what a claim would return, even when that source would not interrupt the target. The selection is a balanced tree of two-input comparators. Its depth grows with log2 of the source count. A parameter chooses between a registered output and a purely combinational output.

Top module: `irq_prio_resolver`

## Requirements
- R1: A source's ID equals its bit index in `pend_i`. Bit 0 is never reported, even when it is pending and enabled.
- R2: A source is a candidate only if its `pend_i` bit and its `en_i` bit are both 1.
- R3: Among the candidates, the reported ID belongs to a source with the largest priority value. The priority of source i is `prio_i[i*PW +: PW]`.
- R4: When several candidates share the largest priority, the smallest ID is reported.
- R5: `req_o` is 1 exactly when a candidate exists and the winner's priority is strictly greater than `thresh_i`. Equal to the threshold gives 0.
- R6: A winner with priority 0 never raises `req_o`. A threshold equal to MAX_PRIO keeps `req_o` at 0 for every input.
- R7: The ID is reported whether or not the winner's priority exceeds the threshold.
- R8: With no candidate, `id_o` is 0 and `req_o` is 0.
- R9: In the default registered mode, `id_o` and `req_o` reflect the inputs sampled at the previous rising edge. While `rst_n` is low, both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | N_SRC | Pending flags; bit i is source ID i; bit 0 is reserved |
| en_i | input | N_SRC | This target's enable mask, one bit per source |
| prio_i | input | N_SRC*PW | Packed per-source priorities; source i at [i*PW +: PW] |
| thresh_i | input | PW | This target's priority threshold |
| req_o | output | 1 | Interrupt request to the target |
| id_o | output | IDW | ID of the selected source; 0 means none |

## Verification
If a comparator node in the tree steers the wrong way, the port shows it one cycle after the inputs are applied. The symptom is an ID that is not the best candidate, either a lower priority or a higher index on a tie. A wrong leaf mask shows up as an ID whose pending or enable bit was clear. It can also show up as a reported bit 0. A fault in the threshold path only flips `req_o` and leaves the ID unchanged. For that reason the bench places the winner's priority just below, at, and above the threshold. Because the outputs are compared against a behavioural model on every clock, any such fault appears within one cycle of the stimulus that exposes it.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   typedef enum logic {
      OUT_COMB = 1'b0,
      OUT_REG  = 1'b1
   } out_mode_e;

   // Bits needed to hold the values 0..v, never less than one.
   function automatic int bits_for(input int v);
      int w;
      w = 1;
      while ((1 << w) <= v) w++;
      return w;
   endfunction

endpackage

// File: rtl/irq_prio_leaf.sv
module irq_prio_leaf
   import irq_prio_pkg::*;
#(
   parameter int N_SRC  = 32,
   parameter int PW     = 3,
   parameter int IDW    = 6,
   parameter int LEAVES = 32
) (
   input  logic [N_SRC-1:0]    pend_i,
   input  logic [N_SRC-1:0]    en_i,
   input  logic [N_SRC*PW-1:0] prio_i,
   output logic [LEAVES-1:0]   lf_vld_o,
   output logic [LEAVES*PW-1:0] lf_prio_o,
   output logic [LEAVES*IDW-1:0] lf_id_o
);

   for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
      if (i == 0 || i >= N_SRC) begin : g_tie
         // reserved ID 0 and power-of-two padding never compete
         assign lf_vld_o[i]              = 1'b0;
         assign lf_prio_o[i*PW +: PW]    = '0;
         assign lf_id_o[i*IDW +: IDW]    = '0;
      end else begin : g_src
         assign lf_vld_o[i]              = pend_i[i] & en_i[i];
         assign lf_prio_o[i*PW +: PW]    = prio_i[i*PW +: PW];
         assign lf_id_o[i*IDW +: IDW]    = IDW'(i);
      end
   end

endmodule

// File: rtl/irq_prio_node.sv
module irq_prio_node #(
   parameter int PW  = 3,
   parameter int IDW = 6
) (
   input  logic           lo_vld_i,
   input  logic [PW-1:0]  lo_prio_i,
   input  logic [IDW-1:0] lo_id_i,
   input  logic           hi_vld_i,
   input  logic [PW-1:0]  hi_prio_i,
   input  logic [IDW-1:0] hi_id_i,
   output logic           vld_o,
   output logic [PW-1:0]  prio_o,
   output logic [IDW-1:0] id_o
);

   logic pick_hi;

   // The lower-index side keeps ties; the upper side needs a strictly larger priority.
   assign pick_hi = hi_vld_i & (~lo_vld_i | (hi_prio_i > lo_prio_i));

   assign vld_o  = lo_vld_i | hi_vld_i;
   assign prio_o = pick_hi ? hi_prio_i : lo_prio_i;
   assign id_o   = pick_hi ? hi_id_i   : lo_id_i;

endmodule

// File: rtl/irq_prio_tree.sv
module irq_prio_tree #(
   parameter int LEAVES = 32,
   parameter int PW     = 3,
   parameter int IDW    = 6
) (
   input  logic [LEAVES-1:0]     lf_vld_i,
   input  logic [LEAVES*PW-1:0]  lf_prio_i,
   input  logic [LEAVES*IDW-1:0] lf_id_i,
   output logic                  win_vld_o,
   output logic [PW-1:0]         win_prio_o,
   output logic [IDW-1:0]        win_id_o
);

   localparam int NODES = 2*LEAVES - 1;
   localparam int FIRST_LEAF = LEAVES - 1;

   // Heap layout: node k has children 2k+1 (lower IDs) and 2k+2 (higher IDs).
   logic           h_vld  [NODES];
   logic [PW-1:0]  h_prio [NODES];
   logic [IDW-1:0] h_id   [NODES];

   for (genvar i = 0; i < LEAVES; i++) begin : g_in
      assign h_vld [FIRST_LEAF+i] = lf_vld_i[i];
      assign h_prio[FIRST_LEAF+i] = lf_prio_i[i*PW +: PW];
      assign h_id  [FIRST_LEAF+i] = lf_id_i[i*IDW +: IDW];
   end

   for (genvar k = 0; k < FIRST_LEAF; k++) begin : g_node
      irq_prio_node #(
         .PW  (PW),
         .IDW (IDW)
      ) u_node (
         .lo_vld_i  (h_vld [2*k+1]),
         .lo_prio_i (h_prio[2*k+1]),
         .lo_id_i   (h_id  [2*k+1]),
         .hi_vld_i  (h_vld [2*k+2]),
         .hi_prio_i (h_prio[2*k+2]),
         .hi_id_i   (h_id  [2*k+2]),
         .vld_o     (h_vld [k]),
         .prio_o    (h_prio[k]),
         .id_o      (h_id  [k])
      );
   end

   assign win_vld_o  = h_vld[0];
   assign win_prio_o = h_prio[0];
   assign win_id_o   = h_id[0];

endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate
   import irq_prio_pkg::*;
#(
   parameter int        PW       = 3,
   parameter int        IDW      = 6,
   parameter out_mode_e OUT_MODE = OUT_REG
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           win_vld_i,
   input  logic [PW-1:0]  win_prio_i,
   input  logic [IDW-1:0] win_id_i,
   input  logic [PW-1:0]  thresh_i,
   output logic           req_o,
   output logic [IDW-1:0] id_o
);

   logic           req_d;
   logic [IDW-1:0] id_d;

   assign req_d = win_vld_i & (win_prio_i > thresh_i);
   assign id_d  = win_vld_i ? win_id_i : '0;

   if (OUT_MODE == OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_o <= 1'b0;
            id_o  <= '0;
         end else begin
            req_o <= req_d;
            id_o  <= id_d;
         end
      end
   end else begin : g_comb
      assign req_o = req_d;
      assign id_o  = id_d;
   end

endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_prio_pkg::*;
#(
   parameter int        N_SRC    = 32,
   parameter int        MAX_PRIO = 7,
   parameter out_mode_e OUT_MODE = OUT_REG,
   localparam int       PW       = bits_for(MAX_PRIO),
   localparam int       IDW      = bits_for(N_SRC)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_SRC-1:0]    pend_i,
   input  logic [N_SRC-1:0]    en_i,
   input  logic [N_SRC*PW-1:0] prio_i,
   input  logic [PW-1:0]       thresh_i,
   output logic                req_o,
   output logic [IDW-1:0]      id_o
);

   localparam int LEAVES = 1 << $clog2(N_SRC);

   if (N_SRC < 2 || N_SRC > 255) begin : g_bad_nsrc
      $error("irq_prio_resolver: N_SRC must lie in 2..255");
   end
   if (MAX_PRIO < 1) begin : g_bad_prio
      $error("irq_prio_resolver: MAX_PRIO must be at least 1");
   end

   logic [LEAVES-1:0]     lf_vld;
   logic [LEAVES*PW-1:0]  lf_prio;
   logic [LEAVES*IDW-1:0] lf_id;
   logic                  win_vld;
   logic [PW-1:0]         win_prio;
   logic [IDW-1:0]        win_id;

   irq_prio_leaf #(
      .N_SRC  (N_SRC),
      .PW     (PW),
      .IDW    (IDW),
      .LEAVES (LEAVES)
   ) u_leaf (
      .pend_i    (pend_i),
      .en_i      (en_i),
      .prio_i    (prio_i),
      .lf_vld_o  (lf_vld),
      .lf_prio_o (lf_prio),
      .lf_id_o   (lf_id)
   );

   irq_prio_tree #(
      .LEAVES (LEAVES),
      .PW     (PW),
      .IDW    (IDW)
   ) u_tree (
      .lf_vld_i   (lf_vld),
      .lf_prio_i  (lf_prio),
      .lf_id_i    (lf_id),
      .win_vld_o  (win_vld),
      .win_prio_o (win_prio),
      .win_id_o   (win_id)
   );

   irq_prio_gate #(
      .PW       (PW),
      .IDW      (IDW),
      .OUT_MODE (OUT_MODE)
   ) u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .win_vld_i  (win_vld),
      .win_prio_i (win_prio),
      .win_id_i   (win_id),
      .thresh_i   (thresh_i),
      .req_o      (req_o),
      .id_o       (id_o)
   );

endmodule

// File: rtl/irq_prio_resolver_chk.sv
module irq_prio_resolver_chk
   import irq_prio_pkg::*;
#(
   parameter int        N_SRC    = 32,
   parameter int        MAX_PRIO = 7,
   parameter out_mode_e OUT_MODE = OUT_REG,
   localparam int       PW       = bits_for(MAX_PRIO),
   localparam int       IDW      = bits_for(N_SRC)
) (
   input logic                clk,
   input logic                rst_n,
   input logic [N_SRC-1:0]    pend_i,
   input logic [N_SRC-1:0]    en_i,
   input logic [N_SRC*PW-1:0] prio_i,
   input logic [PW-1:0]       thresh_i,
   input logic                req_o,
   input logic [IDW-1:0]      id_o
);

   if (OUT_MODE == OUT_REG) begin : g_chk
      logic                seen_q;
      logic [N_SRC-1:0]    elig_q;
      logic [N_SRC*PW-1:0] prio_q;
      logic [PW-1:0]       thr_q;
      logic [PW-1:0]       id_prio;
      logic                better;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen_q <= 1'b0;
            elig_q <= '0;
            prio_q <= '0;
            thr_q  <= '0;
         end else begin
            seen_q <= 1'b1;
            elig_q <= pend_i & en_i;
            prio_q <= prio_i;
            thr_q  <= thresh_i;
         end
      end

      always_comb begin
         id_prio = '0;
         better  = 1'b0;
         for (int i = 1; i < N_SRC; i++) begin
            if (int'(id_o) == i) id_prio = prio_q[i*PW +: PW];
         end
         for (int i = 1; i < N_SRC; i++) begin
            if (elig_q[i]) begin
               if (id_o == '0) better = 1'b1;
               else if (prio_q[i*PW +: PW] > id_prio) better = 1'b1;
               else if (prio_q[i*PW +: PW] == id_prio && i < int'(id_o)) better = 1'b1;
            end
         end
      end

      AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q |-> (int'(id_o) < N_SRC)); // R1
      AST_ID_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && id_o != '0) |-> elig_q[id_o]); // R2
      AST_NO_BETTER_CAND: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q |-> !better); // R3 R4
      AST_REQ_STRICT_THR: assert property (@(posedge clk) disable iff (!rst_n)
         seen_q |-> (req_o == (id_o != '0 && id_prio > thr_q))); // R5
      AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && elig_q[N_SRC-1:1] == '0) |-> (id_o == '0 && !req_o)); // R8
   end

endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(
   .N_SRC    (N_SRC),
   .MAX_PRIO (MAX_PRIO),
   .OUT_MODE (OUT_MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pend_i   (pend_i),
   .en_i     (en_i),
   .prio_i   (prio_i),
   .thresh_i (thresh_i),
   .req_o    (req_o),
   .id_o     (id_o)
);

// File: tb/irq_prio_resolver_bench.sv
`timescale 1ns/1ps
module irq_prio_resolver_bench;

   localparam int N_SRC    = 32;
   localparam int MAX_PRIO = 7;
   localparam int PW       = 3;
   localparam int IDW      = 6;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic [N_SRC-1:0]    pend = '0;
   logic [N_SRC-1:0]    en = '0;
   logic [N_SRC*PW-1:0] prio = '0;
   logic [PW-1:0]       thr = '0;
   logic                req;
   logic [IDW-1:0]      id;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_prio_resolver #(
      .N_SRC    (N_SRC),
      .MAX_PRIO (MAX_PRIO)
   ) u_irq_prio_resolver (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend),
      .en_i     (en),
      .prio_i   (prio),
      .thresh_i (thr),
      .req_o    (req),
      .id_o     (id)
   );

   task automatic check(input string tag, input int act, input int exp, input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic set_prio(input int src, input int p);
      prio[src*PW +: PW] = PW'(p);
   endtask

   // Behavioural model: scan sources in ID order, keep the strictly better one.
   task automatic model(output int e_id, output int e_req);
      int best, bp;
      best = -1;
      bp = 0;
      for (int i = 1; i < N_SRC; i++) begin
         if (pend[i] && en[i]) begin
            if (best < 0 || int'(prio[i*PW +: PW]) > bp) begin
               best = i;
               bp = int'(prio[i*PW +: PW]);
            end
         end
      end
      e_id  = (best < 0) ? 0 : best;
      e_req = (best >= 0 && bp > int'(thr)) ? 1 : 0;
   endtask

   // Inputs are already applied (at a negedge); one rising edge registers them.
   task automatic step(input string tag);
      int e_id, e_req;
      model(e_id, e_req);
      @(posedge clk);
      @(negedge clk);
      check(tag, int'(id), e_id, "id");
      check(tag, int'(req), e_req, "req");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R9: outputs held at zero during reset even with eligible inputs
      pend = '1; en = '1; prio = '1; thr = '0;
      repeat (3) @(negedge clk);
      check("R9", int'(id), 0, "id in reset");
      check("R9", int'(req), 0, "req in reset");
      pend = '0; en = '0; prio = '0;
      rst_n = 1'b1;
      step("R8");

      // R8: nothing enabled although pending
      pend = 32'hFFFF_FFFE; en = '0; thr = 3'd0;
      step("R8");

      // R1: bit 0 pending and enabled with top priority is never reported
      pend = 32'h1; en = '1; prio = '0; set_prio(0, 7);
      step("R1");
      pend = 32'h8000_0001; set_prio(31, 1);
      step("R1");

      // R2: the higher-priority source is disabled
      prio = '0; set_prio(4, 7); set_prio(9, 2);
      pend = (32'h1 << 4) | (32'h1 << 9);
      en = 32'h1 << 9;
      step("R2");
      en = (32'h1 << 4) | (32'h1 << 9); pend = 32'h1 << 9;
      step("R2");

      // R3: highest priority wins regardless of position
      prio = '0; set_prio(3, 2); set_prio(17, 6); set_prio(30, 4);
      pend = (32'h1 << 3) | (32'h1 << 17) | (32'h1 << 30); en = '1; thr = 3'd1;
      step("R3");

      // R4: three-way tie goes to the lowest ID
      prio = '0; set_prio(5, 4); set_prio(9, 4); set_prio(30, 4);
      pend = (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 30);
      step("R4");
      pend[5] = 1'b0;
      step("R4");

      // R5: winner priority equal to the threshold, then one above it
      prio = '0; set_prio(12, 5); pend = 32'h1 << 12; thr = 3'd5;
      step("R5");
      thr = 3'd4;
      step("R5");

      // R6: threshold at MAX_PRIO suppresses; priority 0 never requests
      set_prio(12, 7); thr = 3'(MAX_PRIO);
      step("R6");
      set_prio(12, 0); thr = 3'd0;
      step("R6");

      // R7: the ID is reported although below the threshold
      set_prio(12, 2); thr = 3'd5;
      step("R7");

      // R3: broad pseudo-random patterns compared every cycle
      for (int c = 0; c < 400; c++) begin
         pend = $urandom();
         en   = $urandom() | $urandom();
         for (int s = 0; s < N_SRC; s++) set_prio(s, int'($urandom_range(0, MAX_PRIO)));
         thr  = 3'($urandom_range(0, MAX_PRIO));
         step("R3");
      end

      // R9: asynchronous reset clears live outputs
      prio = '1; pend = '1; en = '1; thr = '0;
      step("R9");
      rst_n = 1'b0;
      #1;
      check("R9", int'(id), 0, "id after reset assert");
      check("R9", int'(req), 0, "req after reset assert");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule